// File: doc/BRIEF.md
# Edge-Triggered Pin Event Generator

This block watches a bank of already-synchronized general purpose pin levels and turns chosen level transitions into one-clock event pulses, one pulse line per pin. Each pulse is meant to feed an interrupt controller input or a DMA synchronization request. For each pin, software picks low-to-high edges, high-to-low edges, both or neither. A single bank enable bit gates every pulse in the bank.

The two per-pin edge-select vectors cannot be written directly. Each vector has a set alias and a clear alias, both write-one. A zero written to either alias changes nothing. Reading either alias of a pair returns the vector behind it. Edges are found by comparing the current pin level with a copy registered on the previous clock. This copy is always kept up to date, so pins driven as outputs raise events when software toggles them, and turning the bank on does not replay an old transition. Register reads return data one clock after the read strobe.

Top module: `gpio_edge_evt`

## Requirements
- R1: After a synchronous reset, the bank enable bit, both edge-select vectors, all event outputs and the read data are 0.
- R2: A write to byte offset 0x24 ORs write-data bits [15:0] into the rising-select vector. Zero bits leave the matching select bits unchanged, and bits [31:16] are ignored.
- R3: A write to offset 0x28 clears each rising-select bit whose write-data bit is 1. Zero bits leave the matching select bits unchanged.
- R4: Offset 0x2C sets falling-select bits and offset 0x30 clears them, with the same write-one behaviour as the rising pair.
- R5: A read strobe returns the value on rd_data on the next clock. Offsets 0x24 and 0x28 return the rising-select vector, and offsets 0x2C and 0x30 return the falling-select vector, both in bits [15:0]. Offset 0x08 returns the bank enable in bit 0 with bits [31:1] zero. Any other offset returns 0.
- R6: When only the rising-select bit of a pin is 1, a 0-to-1 change of that pin gives a pulse on its event bit, and a 1-to-0 change gives none.
- R7: When only the falling-select bit of a pin is 1, a 1-to-0 change gives a pulse, and a 0-to-1 change gives none.
- R8: When both select bits of a pin are 1, every change of that pin gives a pulse. When both are 0, no change of that pin gives one.
- R9: A write to offset 0x08 loads the bank enable from write-data bit 0. While it is 0, no event bit is ever 1.
- R10: The previous-level copy tracks the pins while the bank is disabled. Enabling the bank after a pin changed during the disabled period gives no pulse.
- R11: Each pulse is exactly one clock long. It is registered on the first clock edge that samples the new pin level, and all pins are handled independently, the top pin included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock; also clocks edge detection |
| rst | input | 1 | Synchronous active-high reset |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe |
| acc_addr | input | 8 | Register byte offset |
| acc_wdata | input | 32 | Register write data |
| rd_data | output | 32 | Registered read data, valid the clock after acc_rd |
| pin_lvl | input | 16 | Synchronized pin levels |
| evt_pulse | output | 16 | Registered per-pin one-clock event pulses |

## Verification
A wrong select bit shows at the ports in two ways. The next read of either alias returns the wrong vector. A pin change then either produces an event pulse that should not occur or fails to produce an expected one. Both effects appear one clock after the read strobe or the pin change. A previous-level copy that is stale or fails to update produces a pulse on the clock after the bank is enabled, or a missing or doubled pulse around a transition. Each such fault is visible within two clocks of the stimulus that exposes it.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int unsigned REG_DW = 32;
  localparam int unsigned OFS_W  = 8;

  // Byte offsets; software depends on this placement.
  localparam logic [OFS_W-1:0] OFS_BANK  = 8'h08;
  localparam logic [OFS_W-1:0] OFS_R_SET = 8'h24;
  localparam logic [OFS_W-1:0] OFS_R_CLR = 8'h28;
  localparam logic [OFS_W-1:0] OFS_F_SET = 8'h2C;
  localparam logic [OFS_W-1:0] OFS_F_CLR = 8'h30;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_BANK = 2'd1,
    RSEL_RISE = 2'd2,
    RSEL_FALL = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic bank;
    logic r_set;
    logic r_clr;
    logic f_set;
    logic f_clr;
  } wr_dec_t;
endpackage

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
  import gpio_evt_pkg::*;
#(
  parameter int unsigned PINS = 16,
  parameter int unsigned DW   = REG_DW,
  parameter int unsigned AW   = OFS_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic            rd,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic            bank_en,
  output logic [PINS-1:0] rise_en,
  output logic [PINS-1:0] fall_en,
  output logic [DW-1:0]   rdata
);
  localparam int unsigned PAD_W = DW - PINS;

  logic            bank_q;
  logic [PINS-1:0] rise_q;
  logic [PINS-1:0] fall_q;
  logic [DW-1:0]   rdata_q;
  logic [DW-1:0]   rd_val;
  wr_dec_t         dec;
  rd_sel_e         rsel;
  logic [PINS-1:0] wbits;
  logic            unused_wdata_hi;

  assign wbits           = wdata[PINS-1:0];
  assign unused_wdata_hi = ^wdata[DW-1:PINS];

  always_comb begin
    dec       = '0;
    dec.bank  = (addr == AW'(OFS_BANK));
    dec.r_set = (addr == AW'(OFS_R_SET));
    dec.r_clr = (addr == AW'(OFS_R_CLR));
    dec.f_set = (addr == AW'(OFS_F_SET));
    dec.f_clr = (addr == AW'(OFS_F_CLR));
  end

  always_comb begin
    if (dec.bank)                     rsel = RSEL_BANK;
    else if (dec.r_set || dec.r_clr)  rsel = RSEL_RISE;
    else if (dec.f_set || dec.f_clr)  rsel = RSEL_FALL;
    else                              rsel = RSEL_NONE;
  end

  always_comb begin
    case (rsel)
      RSEL_BANK: rd_val = {{(DW-1){1'b0}}, bank_q};
      RSEL_RISE: rd_val = {{PAD_W{1'b0}}, rise_q};
      RSEL_FALL: rd_val = {{PAD_W{1'b0}}, fall_q};
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= 1'b0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (wr) begin
      if (dec.bank)  bank_q <= wdata[0];
      if (dec.r_set) rise_q <= rise_q | wbits;
      if (dec.r_clr) rise_q <= rise_q & ~wbits;
      if (dec.f_set) fall_q <= fall_q | wbits;
      if (dec.f_clr) fall_q <= fall_q & ~wbits;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rd_val;
    else         rdata_q <= '0;
  end

  assign bank_en = bank_q;
  assign rise_en = rise_q;
  assign fall_en = fall_q;
  assign rdata   = rdata_q;

  AST_RSET_SETS: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == AW'(OFS_R_SET)) |=> ((rise_q & $past(wbits)) == $past(wbits))); // R2
  AST_RCLR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == AW'(OFS_R_CLR)) |=> ((rise_q & $past(wbits)) == '0)); // R3
  AST_FSET_SETS: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == AW'(OFS_F_SET)) |=> ((fall_q & $past(wbits)) == $past(wbits))); // R4
  AST_FCLR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == AW'(OFS_F_CLR)) |=> ((fall_q & $past(wbits)) == '0)); // R4
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(rise_q) && $stable(fall_q) && $stable(bank_q))); // R2
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (rdata == '0)); // R5
  AST_BANK_UPPER: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == AW'(OFS_BANK)) |=> (rdata[DW-1:1] == '0)); // R5
endmodule

// File: rtl/gpio_evt_edge.sv
module gpio_evt_edge #(
  parameter int unsigned PINS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] lvl,
  input  logic [PINS-1:0] rise_en,
  input  logic [PINS-1:0] fall_en,
  input  logic            bank_en,
  output logic [PINS-1:0] evt
);
  logic [PINS-1:0] prev_q;
  logic [PINS-1:0] evt_q;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic went_up;
    logic went_dn;

    assign went_up = lvl[i] & ~prev_q[i];
    assign went_dn = ~lvl[i] & prev_q[i];

    // Previous level follows the pin every clock, bank enabled or not.
    always_ff @(posedge clk) begin
      prev_q[i] <= lvl[i];
    end

    always_ff @(posedge clk) begin
      if (rst) evt_q[i] <= 1'b0;
      else     evt_q[i] <= bank_en & ((went_up & rise_en[i]) | (went_dn & fall_en[i]));
    end

    AST_EVT_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
      evt_q[i] |-> ($past(lvl[i]) != $past(lvl[i], 2))); // R11
    AST_UP_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
      (evt_q[i] && $past(lvl[i])) |-> $past(rise_en[i])); // R6
    AST_DN_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
      (evt_q[i] && !$past(lvl[i])) |-> $past(fall_en[i])); // R7
  end

  assign evt = evt_q;

  AST_EVT_NEEDS_BANK: assert property (@(posedge clk) disable iff (rst)
    (evt_q != '0) |-> $past(bank_en)); // R9
endmodule

// File: rtl/gpio_edge_evt.sv
module gpio_edge_evt
  import gpio_evt_pkg::*;
#(
  parameter int unsigned PINS = 16,
  parameter int unsigned DW   = REG_DW,
  parameter int unsigned AW   = OFS_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc_wr,
  input  logic            acc_rd,
  input  logic [AW-1:0]   acc_addr,
  input  logic [DW-1:0]   acc_wdata,
  output logic [DW-1:0]   rd_data,
  input  logic [PINS-1:0] pin_lvl,
  output logic [PINS-1:0] evt_pulse
);
  logic            bank_en;
  logic [PINS-1:0] rise_en;
  logic [PINS-1:0] fall_en;

  gpio_evt_regs #(.PINS(PINS), .DW(DW), .AW(AW)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr      (acc_wr),
    .rd      (acc_rd),
    .addr    (acc_addr),
    .wdata   (acc_wdata),
    .bank_en (bank_en),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .rdata   (rd_data)
  );

  gpio_evt_edge #(.PINS(PINS)) edge_i (
    .clk     (clk),
    .rst     (rst),
    .lvl     (pin_lvl),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .bank_en (bank_en),
    .evt     (evt_pulse)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (evt_pulse == '0 && rd_data == '0)); // R1
endmodule

// File: tb/gpio_edge_evt_tb.sv
`timescale 1ns/1ps
module gpio_edge_evt_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_wr = 1'b0;
  logic        acc_rd = 1'b0;
  logic [7:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;
  logic [15:0] pin_lvl = '0;
  logic [15:0] evt_pulse;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  gpio_edge_evt dut_i (
    .clk(clk), .rst(rst), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .pin_lvl(pin_lvl), .evt_pulse(evt_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0; acc_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    acc_rd = 1'b1; acc_addr = a;
    @(negedge clk);
    v = rd_data;
    acc_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  // Change pins, expect the pulse on the next clock, then silence.
  task automatic pin_step(input string req, input logic [15:0] v, input logic [15:0] exp);
    @(negedge clk);
    pin_lvl = v;
    @(negedge clk);
    chk(req, {16'h0, evt_pulse}, {16'h0, exp});
    @(negedge clk);
    chk({req, " one-clock R11"}, {16'h0, evt_pulse}, 32'h0);
  endtask

  task automatic t_reset;
    chk("R1 evt after reset", {16'h0, evt_pulse}, 32'h0);
    chk("R1 rdata after reset", rd_data, 32'h0);
    rd_chk("R1 bank", 8'h08, 32'h0);
    rd_chk("R1 rise vec", 8'h24, 32'h0);
    rd_chk("R1 fall vec", 8'h30, 32'h0);
  endtask

  task automatic t_regs;
    wr(8'h24, 32'hFFFF_00F0);
    rd_chk("R2 set rise upper ignored", 8'h24, 32'h0000_00F0);
    rd_chk("R5 clr alias reads rise", 8'h28, 32'h0000_00F0);
    wr(8'h24, 32'h0);
    rd_chk("R2 zero write no effect", 8'h24, 32'h0000_00F0);
    wr(8'h28, 32'h0000_0030);
    rd_chk("R3 clear rise", 8'h24, 32'h0000_00C0);
    wr(8'h28, 32'h0);
    rd_chk("R3 zero clear no effect", 8'h28, 32'h0000_00C0);
    wr(8'h2C, 32'h0000_0F0F);
    rd_chk("R4 set fall via clr alias", 8'h30, 32'h0000_0F0F);
    wr(8'h30, 32'h0000_0003);
    rd_chk("R4 clear fall", 8'h2C, 32'h0000_0F0C);
    rd_chk("R4 rise untouched", 8'h24, 32'h0000_00C0);
    rd_chk("R5 unmapped offset", 8'h10, 32'h0);
    wr(8'h08, 32'hFFFF_FFFF);
    rd_chk("R5 bank bit0 only", 8'h08, 32'h0000_0001);
    wr(8'h28, 32'hFFFF);
    wr(8'h30, 32'hFFFF);
    rd_chk("R3 all cleared", 8'h24, 32'h0);
    rd_chk("R4 all cleared", 8'h2C, 32'h0);
  endtask

  task automatic t_rise;
    wr(8'h24, 32'h0001);
    pin_step("R6 rise fires", 16'h0001, 16'h0001);
    pin_step("R6 fall silent", 16'h0000, 16'h0000);
    wr(8'h28, 32'h0001);
  endtask

  task automatic t_fall;
    wr(8'h2C, 32'h0002);
    pin_step("R7 rise silent", 16'h0002, 16'h0000);
    pin_step("R7 fall fires", 16'h0000, 16'h0002);
    wr(8'h30, 32'h0002);
  endtask

  task automatic t_both;
    wr(8'h24, 32'h0004);
    wr(8'h2C, 32'h0004);
    pin_step("R8 both up, pin8 none", 16'h0104, 16'h0004);
    pin_step("R8 both down, pin8 none", 16'h0000, 16'h0004);
  endtask

  task automatic t_bank;
    wr(8'h08, 32'h0);
    pin_step("R9 disabled no event", 16'h0004, 16'h0000);
    wr(8'h08, 32'h1);
    chk("R10 no spurious on enable", {16'h0, evt_pulse}, 32'h0);
    @(negedge clk);
    chk("R10 no spurious on enable +1", {16'h0, evt_pulse}, 32'h0);
    pin_step("R9 enabled again fires", 16'h0000, 16'h0004);
    wr(8'h28, 32'hFFFF);
    wr(8'h30, 32'hFFFF);
  endtask

  task automatic t_wide;
    wr(8'h24, 32'hFFFF);
    pin_step("R11 all pins rise", 16'hFFFF, 16'hFFFF);
    pin_step("R11 all pins fall silent", 16'h0000, 16'h0000);
    wr(8'h2C, 32'h8000);
    wr(8'h28, 32'h7FFF);
    pin_step("R11 top pin alone up", 16'h8001, 16'h8000);
    pin_step("R11 top pin down", 16'h0000, 16'h8000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_rise();
    t_fall();
    t_both();
    t_bank();
    t_wide();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule